// File: doc/BRIEF.md
# Greedy Attention Candidate Selector

This block narrows the set of keys that one attention query needs to be scored against, and it does so without computing any full query-key dot product. Each key dimension is held as a column that has already been sorted from largest to smallest value. Every entry in a column carries the index of the key it came from. When a query vector is accepted, the block runs a fixed number of greedy steps, one per clock. In each step it finds the single largest and the single most negative query-element by key-element product that remains across all dimensions. It adds these two products to running score estimates for the keys they belong to, and it removes the used elements from further consideration.

When the programmed number of steps is done, every key with a positive estimate counts as a candidate. The block streams the candidate key indices out one per cycle, lowest index first, up to a fixed limit. It then raises a one-cycle done flag. A downstream exact-rescoring stage consumes the indices. Loading the sorted columns is done ahead of time through a simple write port.

Top module: `acs_selector`

## Requirements
- R1: After reset, qReady is 1 and both candValid and candDone are 0.
- R2: A write with loadValid=1 stores loadValue and loadKey at position loadPos of column loadDim. In each column, position 0 holds the largest value and values do not increase with position. The key tag is the index of the key that owns the element.
- R3: A query is accepted on a clock edge where qValid and qReady are both 1. It captures qData, with dimension d in bits [8d+7:8d], and iterCount. qReady stays 0 from that edge until the edge after candDone. candValid is never 1 while qReady is 1.
- R4: The first cycle that shows candValid or candDone follows the accepting edge by exactly iterCount clock edges. iterCount=0 therefore goes straight to output.
- R5: The maximum path runs in every step. Among the dimensions that still have elements left, it takes the largest product: query element times the top remaining element if the query element is zero or positive, or times the bottom remaining element otherwise. Ties go to the lowest dimension. The product is added to that element's key estimate, and that end of the column is consumed.
- R6: The minimum path runs in the same step and does the same for the most negative product. It uses the bottom element for a zero or positive query element and the top element otherwise. Ties again go to the lowest dimension.
- R7: A dimension whose top and bottom pointers have crossed takes no further part. If the dimension the maximum path picked has exactly one element left, the minimum path skips that dimension in that step.
- R8: At the end of the steps, keys with an estimate greater than zero are emitted on candIdx with candValid=1. They come one per cycle in ascending index order, and at most CAND_MAX (4) of them are emitted. When more keys qualify, the lowest-indexed ones are the ones emitted.
- R9: candDone pulses for one cycle, in the cycle right after the last emitted candidate, or in the first output cycle if there are no candidates. The block then returns to accepting queries.
- R10: Estimates and pointers are cleared when each query is accepted, so repeating a query gives the same candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Column write strobe |
| loadDim | input | 3 | Column (dimension) to write |
| loadPos | input | 4 | Sorted position within the column |
| loadValue | input | 8 | Signed key element |
| loadKey | input | 4 | Index of the key owning the element |
| qValid | input | 1 | Query present |
| qReady | output | 1 | Block idle and able to accept a query |
| qData | input | 64 | Signed query elements, 8 bits per dimension |
| iterCount | input | 8 | Number of greedy steps for this query |
| candValid | output | 1 | candIdx carries a candidate this cycle |
| candIdx | output | 4 | Candidate key index |
| candDone | output | 1 | One-cycle end-of-list flag |

## Verification
Some properties are checked by the embedded assertions on every cycle. In each dimension the top pointer never passes the bottom bound. The output valid never overlaps query ready. The emitted count never exceeds the limit. Indices within one burst strictly ascend. Every done pulse is followed by a return to idle.

Other behaviour can only be shown by the directed scenarios, which run an independent model of the greedy search. These cover the per-step choices of the maximum and minimum paths, tie-breaking, the skip rule for a single remaining element, the exact latency against the step count, truncation to the limit, and the clearing of state between queries.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EMIT} acsState_t;

  typedef struct packed {
    logic clearRun;   // start of a query: capture it, reset pointers and estimates
    logic stepEn;     // perform one greedy step
    logic emitTake;   // current lowest pending candidate is emitted
  } acsStrobes_t;
endpackage

// File: rtl/acs_ctrl.sv
module acs_ctrl
  import acs_pkg::*;
#(
  parameter int ITER_W   = 8,
  parameter int CAND_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              qValid,
  input  logic [ITER_W-1:0] iterCount,
  input  logic              foundNext,
  output logic              qReady,
  output logic              candValid,
  output logic              candDone,
  output acsStrobes_t       strobes
);
  localparam int CNT_W = $clog2(CAND_MAX + 1);

  acsState_t         state;
  logic [ITER_W-1:0] iterLeft;
  logic [CNT_W-1:0]  candCnt;
  logic              take;

  assign take      = (state == ST_EMIT) && foundNext && (candCnt < CNT_W'(CAND_MAX));
  assign qReady    = (state == ST_IDLE);
  assign candValid = take;
  assign candDone  = (state == ST_EMIT) && !take;

  always_comb begin
    strobes          = '0;
    strobes.clearRun = qReady && qValid;
    strobes.stepEn   = (state == ST_RUN);
    strobes.emitTake = take;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      iterLeft <= '0;
      candCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (qValid) begin
          candCnt  <= '0;
          iterLeft <= iterCount;
          state    <= (iterCount == '0) ? ST_EMIT : ST_RUN;
        end
        ST_RUN: begin
          iterLeft <= iterLeft - 1'b1;
          if (iterLeft == ITER_W'(1)) state <= ST_EMIT;
        end
        ST_EMIT: begin
          if (take) candCnt <= candCnt + 1'b1;
          else      state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  valid_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(candValid && qReady));

  // R8
  cand_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    candCnt <= CNT_W'(CAND_MAX));

  // R9
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    candDone |=> qReady);
endmodule

// File: rtl/acs_datapath.sv
module acs_datapath
  import acs_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  parameter int NUM_DIMS = 8,
  parameter int ELEM_W   = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  acsStrobes_t                  strobes,
  input  logic                         loadEn,
  input  logic [$clog2(NUM_DIMS)-1:0]  loadDim,
  input  logic [$clog2(NUM_KEYS)-1:0]  loadPos,
  input  logic signed [ELEM_W-1:0]     loadValue,
  input  logic [$clog2(NUM_KEYS)-1:0]  loadKey,
  input  logic [NUM_DIMS*ELEM_W-1:0]   qData,
  output logic                         foundNext,
  output logic [$clog2(NUM_KEYS)-1:0]  nextIdx
);
  localparam int KEY_W  = $clog2(NUM_KEYS);
  localparam int DIM_W  = $clog2(NUM_DIMS);
  localparam int PTR_W  = $clog2(NUM_KEYS + 1);
  localparam int PROD_W = 2 * ELEM_W;
  // each (dim,key) element is consumed once, so a key sums at most NUM_DIMS products
  localparam int ACC_W  = PROD_W + $clog2(NUM_DIMS) + 2;

  logic signed [ELEM_W-1:0] colVal [NUM_DIMS][NUM_KEYS];
  logic [KEY_W-1:0]         colKey [NUM_DIMS][NUM_KEYS];
  logic signed [ELEM_W-1:0] qReg   [NUM_DIMS];
  logic [PTR_W-1:0]         hiPtr  [NUM_DIMS];
  logic [PTR_W-1:0]         endPtr [NUM_DIMS];
  logic signed [ACC_W-1:0]  est    [NUM_KEYS];
  logic [NUM_KEYS-1:0]      emitted;

  logic [NUM_DIMS-1:0]      active, single, qPos;
  logic signed [PROD_W-1:0] maxProd [NUM_DIMS];
  logic signed [PROD_W-1:0] minProd [NUM_DIMS];
  logic [KEY_W-1:0]         hiKey [NUM_DIMS];
  logic [KEY_W-1:0]         loKey [NUM_DIMS];
  logic signed [PROD_W-1:0] bestMax, bestMin;
  logic                     maxFound, minFound;
  logic [DIM_W-1:0]         maxDim, minDim;
  logic [KEY_W-1:0]         maxKeySel, minKeySel;
  logic signed [ACC_W-1:0]  maxAdd, minAdd;

  always_ff @(posedge clk) begin
    if (loadEn) begin
      colVal[loadDim][loadPos] <= loadValue;
      colKey[loadDim][loadPos] <= loadKey;
    end
  end

  // per-dimension candidate products at both ends
  always_comb begin
    for (int d = 0; d < NUM_DIMS; d++) begin
      logic [KEY_W-1:0] hiIdx, loIdx;
      logic signed [PROD_W-1:0] pHi, pLo;
      hiIdx     = hiPtr[d][KEY_W-1:0];
      loIdx     = KEY_W'(endPtr[d] - PTR_W'(1));
      active[d] = hiPtr[d] < endPtr[d];
      single[d] = (endPtr[d] - hiPtr[d]) == PTR_W'(1);
      qPos[d]   = !qReg[d][ELEM_W-1];
      pHi       = PROD_W'(qReg[d]) * PROD_W'(colVal[d][hiIdx]);
      pLo       = PROD_W'(qReg[d]) * PROD_W'(colVal[d][loIdx]);
      hiKey[d]  = colKey[d][hiIdx];
      loKey[d]  = colKey[d][loIdx];
      maxProd[d] = qPos[d] ? pHi : pLo;
      minProd[d] = qPos[d] ? pLo : pHi;
    end
  end

  // greedy argmax / argmin across dimensions, lowest dimension wins ties
  always_comb begin
    maxFound = 1'b0; bestMax = '0; maxDim = '0;
    for (int d = 0; d < NUM_DIMS; d++) begin
      if (active[d] && (!maxFound || maxProd[d] > bestMax)) begin
        maxFound = 1'b1; bestMax = maxProd[d]; maxDim = DIM_W'(d);
      end
    end
    minFound = 1'b0; bestMin = '0; minDim = '0;
    for (int d = 0; d < NUM_DIMS; d++) begin
      if (active[d] && !(maxFound && maxDim == DIM_W'(d) && single[d]) &&
          (!minFound || minProd[d] < bestMin)) begin
        minFound = 1'b1; bestMin = minProd[d]; minDim = DIM_W'(d);
      end
    end
    maxKeySel = qPos[maxDim] ? hiKey[maxDim] : loKey[maxDim];
    minKeySel = qPos[minDim] ? loKey[minDim] : hiKey[minDim];
    maxAdd    = maxFound ? ACC_W'(bestMax) : '0;
    minAdd    = minFound ? ACC_W'(bestMin) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearRun) begin
      for (int d = 0; d < NUM_DIMS; d++) begin
        hiPtr[d]  <= '0;
        endPtr[d] <= PTR_W'(NUM_KEYS);
        qReg[d]   <= rstN ? qData[d*ELEM_W +: ELEM_W] : '0;
      end
      for (int k = 0; k < NUM_KEYS; k++) est[k] <= '0;
      emitted <= '0;
    end else begin
      if (strobes.stepEn) begin
        for (int d = 0; d < NUM_DIMS; d++) begin
          logic maxHere, minHere;
          maxHere = maxFound && maxDim == DIM_W'(d);
          minHere = minFound && minDim == DIM_W'(d);
          if ((maxHere && qPos[d]) || (minHere && !qPos[d]))
            hiPtr[d] <= hiPtr[d] + 1'b1;
          if ((maxHere && !qPos[d]) || (minHere && qPos[d]))
            endPtr[d] <= endPtr[d] - 1'b1;
        end
        for (int k = 0; k < NUM_KEYS; k++)
          est[k] <= est[k]
                  + ((maxKeySel == KEY_W'(k)) ? maxAdd : '0)
                  + ((minKeySel == KEY_W'(k)) ? minAdd : '0);
      end
      if (strobes.emitTake) emitted[nextIdx] <= 1'b1;
    end
  end

  // lowest-index key with a positive estimate not yet emitted
  always_comb begin
    foundNext = 1'b0; nextIdx = '0;
    for (int k = NUM_KEYS - 1; k >= 0; k--) begin
      if (est[k] > 0 && !emitted[k]) begin
        foundNext = 1'b1; nextIdx = KEY_W'(k);
      end
    end
  end

  for (genvar g = 0; g < NUM_DIMS; g++) begin : gPtrChk
    // R7
    ptr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
      hiPtr[g] <= endPtr[g]);
  end

  // R8
  ascending_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emitTake && $past(strobes.emitTake)) |-> nextIdx > $past(nextIdx));
endmodule

// File: rtl/acs_selector.sv
module acs_selector
  import acs_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  parameter int NUM_DIMS = 8,
  parameter int ELEM_W   = 8,
  parameter int ITER_W   = 8,
  parameter int CAND_MAX = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        loadValid,
  input  logic [$clog2(NUM_DIMS)-1:0] loadDim,
  input  logic [$clog2(NUM_KEYS)-1:0] loadPos,
  input  logic signed [ELEM_W-1:0]    loadValue,
  input  logic [$clog2(NUM_KEYS)-1:0] loadKey,
  input  logic                        qValid,
  output logic                        qReady,
  input  logic [NUM_DIMS*ELEM_W-1:0]  qData,
  input  logic [ITER_W-1:0]           iterCount,
  output logic                        candValid,
  output logic [$clog2(NUM_KEYS)-1:0] candIdx,
  output logic                        candDone
);
  acsStrobes_t strobes;
  logic        foundNext;

  acs_ctrl #(.ITER_W(ITER_W), .CAND_MAX(CAND_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN), .qValid(qValid), .iterCount(iterCount),
    .foundNext(foundNext), .qReady(qReady), .candValid(candValid),
    .candDone(candDone), .strobes(strobes)
  );

  acs_datapath #(.NUM_KEYS(NUM_KEYS), .NUM_DIMS(NUM_DIMS), .ELEM_W(ELEM_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadEn(loadValid),
    .loadDim(loadDim), .loadPos(loadPos), .loadValue(loadValue), .loadKey(loadKey),
    .qData(qData), .foundNext(foundNext), .nextIdx(candIdx)
  );
endmodule

// File: tb/acs_selector_tb_top.sv
module acs_selector_tb_top;
  localparam int NK = 16, ND = 8, CMAX = 4;

  logic clk = 0, rstN = 0;
  logic loadValid = 0;
  logic [2:0] loadDim = 0;
  logic [3:0] loadPos = 0, loadKey = 0;
  logic signed [7:0] loadValue = 0;
  logic qValid = 0, qReady, candValid, candDone;
  logic [63:0] qData = 0;
  logic [7:0] iterCount = 0;
  logic [3:0] candIdx;

  int checkCnt = 0, failCnt = 0;
  int sVal [ND][NK];
  int sKey [ND][NK];
  int expList [NK];
  int expN;

  always #4 clk = ~clk;

  acs_selector dut_i (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadDim(loadDim),
    .loadPos(loadPos), .loadValue(loadValue), .loadKey(loadKey),
    .qValid(qValid), .qReady(qReady), .qData(qData), .iterCount(iterCount),
    .candValid(candValid), .candIdx(candIdx), .candDone(candDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // build a key matrix, sort each column descending and load it (R2)
  task automatic loadMatrix(input int seed);
    int m [NK][ND];
    for (int k = 0; k < NK; k++)
      for (int d = 0; d < ND; d++)
        m[k][d] = ((k * 37 + d * 53 + seed * 19) % 97) - 48;
    for (int d = 0; d < ND; d++) begin
      bit used [NK];
      for (int k = 0; k < NK; k++) used[k] = 0;
      for (int p = 0; p < NK; p++) begin
        int b = -1;
        for (int k = 0; k < NK; k++)
          if (!used[k] && (b < 0 || m[k][d] > m[b][d])) b = k;
        used[b] = 1;
        sVal[d][p] = m[b][d];
        sKey[d][p] = b;
      end
    end
    for (int d = 0; d < ND; d++)
      for (int p = 0; p < NK; p++) begin
        @(negedge clk);
        loadValid = 1; loadDim = 3'(d); loadPos = 4'(p);
        loadValue = 8'(sVal[d][p]); loadKey = 4'(sKey[d][p]);
      end
    @(negedge clk);
    loadValid = 0;
  endtask

  // independent greedy model following R5, R6, R7, R8
  task automatic model(input int q [ND], input int iters);
    int hi [ND], en [ND];
    longint est [NK];
    for (int d = 0; d < ND; d++) begin hi[d] = 0; en[d] = NK; end
    for (int k = 0; k < NK; k++) est[k] = 0;
    for (int it = 0; it < iters; it++) begin
      int maxD = -1, minD = -1, bMax = 0, bMin = 0, kMax = 0, kMin = 0;
      for (int d = 0; d < ND; d++)
        if (hi[d] < en[d]) begin
          int p = (q[d] >= 0) ? q[d] * sVal[d][hi[d]] : q[d] * sVal[d][en[d]-1];
          if (maxD < 0 || p > bMax) begin maxD = d; bMax = p; end
        end
      for (int d = 0; d < ND; d++)
        if (hi[d] < en[d] && !(d == maxD && en[d] - hi[d] == 1)) begin
          int p = (q[d] >= 0) ? q[d] * sVal[d][en[d]-1] : q[d] * sVal[d][hi[d]];
          if (minD < 0 || p < bMin) begin minD = d; bMin = p; end
        end
      if (maxD >= 0) kMax = (q[maxD] >= 0) ? sKey[maxD][hi[maxD]] : sKey[maxD][en[maxD]-1];
      if (minD >= 0) kMin = (q[minD] >= 0) ? sKey[minD][en[minD]-1] : sKey[minD][hi[minD]];
      if (maxD >= 0) begin
        est[kMax] += bMax;
        if (q[maxD] >= 0) hi[maxD]++; else en[maxD]--;
      end
      if (minD >= 0) begin
        est[kMin] += bMin;
        if (q[minD] >= 0) en[minD]--; else hi[minD]++;
      end
    end
    expN = 0;
    for (int k = 0; k < NK; k++)
      if (est[k] > 0 && expN < CMAX) begin expList[expN] = k; expN++; end
  endtask

  task automatic runQuery(input int q [ND], input int iters, input string tag);
    int got [NK];
    int gotN = 0, lat = 0;
    model(q, iters);
    @(negedge clk);
    chk(qReady == 1, {tag, " R3 ready before accept"}, int'(qReady), 1);
    qValid = 1; iterCount = 8'(iters);
    for (int d = 0; d < ND; d++) qData[d*8 +: 8] = 8'(q[d]);
    @(posedge clk);
    @(negedge clk);
    qValid = 0;
    chk(qReady == 0, {tag, " R3 busy after accept"}, int'(qReady), 0);
    while (!candValid && !candDone) begin
      chk(qReady == 0, {tag, " R3 busy while stepping"}, int'(qReady), 0);
      @(posedge clk); @(negedge clk);
      lat++;
    end
    chk(lat == iters, {tag, " R4 latency"}, lat, iters);
    while (!candDone) begin
      if (gotN < NK) got[gotN] = int'(candIdx);
      gotN++;
      @(posedge clk); @(negedge clk);
    end
    chk(gotN == expN, {tag, " R8 candidate count"}, gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++)
      chk(got[i] == expList[i], {tag, " R5 R6 R8 candidate index"}, got[i], expList[i]);
    @(posedge clk); @(negedge clk);
    chk(candDone == 0, {tag, " R9 done is one pulse"}, int'(candDone), 0);
    chk(qReady == 1, {tag, " R9 ready after done"}, int'(qReady), 1);
  endtask

  task automatic test_reset;
    chk(qReady == 1, "R1 qReady", int'(qReady), 1);
    chk(candValid == 0, "R1 candValid", int'(candValid), 0);
    chk(candDone == 0, "R1 candDone", int'(candDone), 0);
  endtask

  task automatic test_positive_query;
    int q [ND];
    for (int d = 0; d < ND; d++) q[d] = (d * 13 + 5) % 50;
    runQuery(q, 4, "positive");
  endtask

  task automatic test_mixed_sign;
    int q [ND];
    for (int d = 0; d < ND; d++) q[d] = ((d * 29 + 41) % 91) - 45;
    runQuery(q, 12, "mixed");
  endtask

  task automatic test_zero_iters;
    int q [ND];
    for (int d = 0; d < ND; d++) q[d] = 20;
    runQuery(q, 0, "zero-iters R4");
  endtask

  task automatic test_exhaust;
    int q [ND];
    for (int d = 0; d < ND; d++) q[d] = ((d * 17 + 3) % 60) - 25;
    runQuery(q, 80, "exhaust R7");
  endtask

  task automatic test_repeat;
    int q [ND];
    for (int d = 0; d < ND; d++) q[d] = ((d * 31 + 7) % 70) - 30;
    runQuery(q, 9, "repeat-a R10");
    runQuery(q, 9, "repeat-b R10");
  endtask

  task automatic test_zero_query;
    int q [ND];
    for (int d = 0; d < ND; d++) q[d] = 0;
    runQuery(q, 6, "zero-query R5");
  endtask

  initial begin
    #(8 * 200000);
    checkCnt++; failCnt++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    test_reset();
    loadMatrix(1);
    test_positive_query();
    test_mixed_sign();
    test_zero_iters();
    test_exhaust();
    loadMatrix(5);
    test_repeat();
    test_zero_query();
    test_mixed_sign();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule